// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block maps a 14-bit virtual address onto a 12-bit physical address through a 16-entry buffer arranged as four sets of four ways. The low six address bits are the byte position inside a 64-byte page and pass through unchanged. The eight bits above them form the virtual page number. Its bottom two bits pick the set, and its top six bits are the tag compared against all four ways of that set at once. A request also carries the access kind (read or write) and the privilege level (supervisor or user). The response appears one clock later. It carries the physical address on a permitted hit, a one-cycle miss pulse when no entry matches, or a fault flag when an entry matches but its rights forbid the access.

After a miss, the surrounding logic walks the page table elsewhere and writes the result back through a separate refill port. The refill carries the page number, the physical page and three rights bits (readable, writable, user-accessible). A flush input drops every entry in one cycle, for use when the address space changes.

Top module: `tlb_xlate`

## Requirements
- R1: On a permitted hit, rsp_paddr_o equals {entry physical page, req_vaddr_i[5:0]} in the cycle after the request, with rsp_hit_o=1 and rsp_fault_o=0.
- R2: The set index is req_vaddr_i[7:6] and the tag is req_vaddr_i[13:8]; a hit needs a valid entry in that set with an equal tag, and entries in other sets never match.
- R3: A request with no matching entry gives rsp_miss_o=1 and rsp_hit_o=0 for one cycle, with rsp_paddr_o=0.
- R4: A read needs the readable bit and a write needs the writable bit; a matching entry without the needed bit gives rsp_hit_o=1, rsp_fault_o=1 and rsp_paddr_o=0.
- R5: With req_super_i=0 (user), a matching entry whose user bit is 0 faults; with req_super_i=1 only the read/write bits apply.
- R6: A refill (fill_vpn_i[1:0] = set, fill_vpn_i[7:2] = tag) writes the way that already holds that tag; failing that, the lowest-numbered invalid way; failing that, the way named by the set's round-robin pointer, which then advances by one modulo 4. Only that last case moves the pointer.
- R7: flush_i clears every valid bit in one cycle; a refill in the same cycle is discarded; round-robin pointers are kept.
- R8: A lookup in the same cycle as a refill or flush sees the contents from before that update.
- R9: A cycle without a request gives rsp_valid_o=0, all flags 0 and rsp_paddr_o=0 in the next cycle.
- R10: After reset all entries are invalid, all pointers are 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 14 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_super_i | input | 1 | 1 = supervisor, 0 = user |
| flush_i | input | 1 | Invalidate all entries |
| fill_valid_i | input | 1 | Refill write strobe |
| fill_vpn_i | input | 8 | Virtual page number to install |
| fill_ppn_i | input | 6 | Physical page number to install |
| fill_rd_i | input | 1 | Page readable |
| fill_wr_i | input | 1 | Page writable |
| fill_user_i | input | 1 | Page reachable from user mode |
| rsp_valid_o | output | 1 | Response for previous-cycle request |
| rsp_hit_o | output | 1 | Matching entry found |
| rsp_miss_o | output | 1 | No matching entry |
| rsp_fault_o | output | 1 | Match but access denied |
| rsp_paddr_o | output | 12 | Physical address, 0 unless permitted hit |

## Verification
Round-robin eviction is the hardest case to reach from the ports. It only fires when a set is full and the refilled tag is new, and its effect shows only later, as a miss on whichever tag was displaced. The stimulus fills one set with five distinct tags and probes each one. The random phase then draws tags from a narrow pool over a single set-heavy address range, so full sets, re-refills of present tags and evictions recur often. A bench model tracks pointer state and predicts every later hit or miss. Same-cycle lookup/refill and flush/refill pairs are also driven on purpose.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 14;
  localparam int PA_W  = 12;
  localparam int OFF_W = 6;
  localparam int SET_W = 2;
  localparam int WAYS  = 4;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = $clog2(WAYS);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic             rd;
    logic             wr;
    logic             usr;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store import tlb_pkg::*; (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        wr_en_i,
  input  logic [SET_W-1:0]            wr_set_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  tlb_ent_t                    wr_ent_i,
  input  logic [SET_W-1:0]            lk_set_i,
  output logic [WAYS-1:0]             lk_vld_o,
  output tlb_ent_t [WAYS-1:0]         lk_ent_o,
  input  logic [SET_W-1:0]            fl_set_i,
  output logic [WAYS-1:0]             fl_vld_o,
  output logic [WAYS-1:0][TAG_W-1:0]  fl_tag_o
);
  logic     [SETS-1:0][WAYS-1:0] valid_q;
  tlb_ent_t [SETS-1:0][WAYS-1:0] ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ent_q   <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_set_i][wr_way_i] <= 1'b1;
      ent_q[wr_set_i][wr_way_i]   <= wr_ent_i;
    end
  end

  assign lk_vld_o = valid_q[lk_set_i];
  assign lk_ent_o = ent_q[lk_set_i];
  assign fl_vld_o = valid_q[fl_set_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_ftag
    assign fl_tag_o[w] = ent_q[fl_set_i][w].tag;
  end

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R7
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i) |=> valid_q[$past(wr_set_i)][$past(wr_way_i)]); // R6
endmodule

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; (
  input  logic [WAYS-1:0]     vld_i,
  input  tlb_ent_t [WAYS-1:0] ent_i,
  input  logic [TAG_W-1:0]    tag_i,
  output logic                hit_o,
  output logic [WAYS-1:0]     match_o,
  output tlb_ent_t            ent_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = vld_i[w] && (ent_i[w].tag == tag_i);
  end

  // OR-mux: at most one way matches
  always_comb begin
    ent_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match_o[w]) ent_o = ent_o | ent_i[w];
  end

  assign hit_o = |match_o;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm import tlb_pkg::*; (
  input  tlb_ent_t ent_i,
  input  logic     write_i,
  input  logic     super_i,
  output logic     deny_o
);
  logic kind_ok, priv_ok;
  assign kind_ok = write_i ? ent_i.wr : ent_i.rd;
  assign priv_ok = super_i || ent_i.usr;
  assign deny_o  = !(kind_ok && priv_ok);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim import tlb_pkg::*; (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        fill_en_i,
  input  logic [SET_W-1:0]            set_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [WAYS-1:0]             vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  output logic [WAY_W-1:0]            way_o,
  output logic [WAYS-1:0]             match_o
);
  logic [SETS-1:0][WAY_W-1:0] rr_q;
  logic             any_m, any_free, use_rr;
  logic [WAY_W-1:0] m_way, f_way;

  always_comb begin
    any_m = 1'b0; m_way = '0;
    any_free = 1'b0; f_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      match_o[w] = vld_i[w] && (tags_i[w] == tag_i);
      if (match_o[w]) begin any_m = 1'b1; m_way = WAY_W'(w); end
      if (!vld_i[w])  begin any_free = 1'b1; f_way = WAY_W'(w); end
    end
    use_rr = !any_m && !any_free;
    way_o  = any_m ? m_way : (any_free ? f_way : rr_q[set_i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rr_q <= '0;
    else if (fill_en_i && use_rr) rr_q[set_i] <= rr_q[set_i] + 1'b1;
  end

  AST_RR_HOLDS_UNLESS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fill_en_i || !(&vld_i)) |=> $stable(rr_q)); // R6
  AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |-> $onehot0(match_o)); // R6
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate import tlb_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic              req_write_i,
  input  logic              req_super_i,
  input  logic              flush_i,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic              fill_rd_i,
  input  logic              fill_wr_i,
  input  logic              fill_user_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic              rsp_fault_o,
  output logic [PA_W-1:0]   rsp_paddr_o
);
  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_set = req_vaddr_i[OFF_W +: SET_W];
  assign lk_tag = req_vaddr_i[OFF_W+SET_W +: TAG_W];
  assign fl_set = fill_vpn_i[SET_W-1:0];
  assign fl_tag = fill_vpn_i[SET_W +: TAG_W];

  logic                       wr_en;
  logic [WAY_W-1:0]           fl_way;
  tlb_ent_t                   fl_ent;
  logic [WAYS-1:0]            lk_vld, fl_vld, lk_match, fl_match;
  tlb_ent_t [WAYS-1:0]        lk_ents;
  logic [WAYS-1:0][TAG_W-1:0] fl_tags;
  tlb_ent_t                   lk_ent;
  logic                       lk_hit, lk_deny;

  assign wr_en  = fill_valid_i && !flush_i;
  assign fl_ent = '{tag: fl_tag, ppn: fill_ppn_i, rd: fill_rd_i, wr: fill_wr_i, usr: fill_user_i};

  tlb_store u_store (
    .clk_i, .rst_ni, .flush_i,
    .wr_en_i(wr_en), .wr_set_i(fl_set), .wr_way_i(fl_way), .wr_ent_i(fl_ent),
    .lk_set_i(lk_set), .lk_vld_o(lk_vld), .lk_ent_o(lk_ents),
    .fl_set_i(fl_set), .fl_vld_o(fl_vld), .fl_tag_o(fl_tags)
  );

  tlb_victim u_victim (
    .clk_i, .rst_ni, .fill_en_i(wr_en), .set_i(fl_set), .tag_i(fl_tag),
    .vld_i(fl_vld), .tags_i(fl_tags), .way_o(fl_way), .match_o(fl_match)
  );

  tlb_match u_match (
    .vld_i(lk_vld), .ent_i(lk_ents), .tag_i(lk_tag),
    .hit_o(lk_hit), .match_o(lk_match), .ent_o(lk_ent)
  );

  tlb_perm u_perm (
    .ent_i(lk_ent), .write_i(req_write_i), .super_i(req_super_i), .deny_o(lk_deny)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && lk_hit;
      rsp_miss_o  <= req_valid_i && !lk_hit;
      rsp_fault_o <= req_valid_i && lk_hit && lk_deny;
      rsp_paddr_o <= (req_valid_i && lk_hit && !lk_deny) ?
                     {lk_ent.ppn, req_vaddr_i[OFF_W-1:0]} : '0;
    end
  end

  AST_NO_MULTIHIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot0(lk_match)); // R2
  AST_MISS_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> (!rsp_hit_o && rsp_paddr_o == '0)); // R3
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_hit_o && rsp_paddr_o == '0)); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && lk_hit && !lk_deny) |=> (rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0]))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_hit_o || rsp_miss_o || rsp_fault_o)); // R9
endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_super = 0, flush = 0;
  logic [13:0] req_vaddr = '0;
  logic        fill_valid = 0, fill_rd = 0, fill_wr = 0, fill_user = 0;
  logic [7:0]  fill_vpn = '0;
  logic [5:0]  fill_ppn = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [11:0] rsp_paddr;

  int nvec = 0, nbad = 0;

  bit       m_v  [4][4];
  bit [5:0] m_tag[4][4];
  bit [5:0] m_ppn[4][4];
  bit       m_rd [4][4];
  bit       m_wr [4][4];
  bit       m_us [4][4];
  bit [1:0] m_rr [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_super_i(req_super), .flush_i(flush),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_rd_i(fill_rd), .fill_wr_i(fill_wr), .fill_user_i(fill_user),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr)
  );

  // expected {valid,hit,miss,fault,paddr} from model state before this edge
  function automatic bit [15:0] expect_rsp(bit rq, bit [13:0] va, bit wr, bit sup);
    bit [1:0] s = va[7:6];
    bit hit = 0, deny;
    bit [5:0] pp = '0;
    bit rdp = 0, wrp = 0, usp = 0;
    if (!rq) return 16'h0;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_tag[s][w] == va[13:8]) begin
        hit = 1; pp = m_ppn[s][w]; rdp = m_rd[s][w]; wrp = m_wr[s][w]; usp = m_us[s][w];
      end
    if (!hit) return {4'b1010, 12'h0};
    deny = (wr ? !wrp : !rdp) || (!sup && !usp);
    return deny ? {4'b1101, 12'h0} : {4'b1100, pp, va[5:0]};
  endfunction

  function automatic void model_update(bit fl, bit fv, bit [7:0] vpn, bit [5:0] ppn,
                                       bit rd, bit wr, bit us);
    bit [1:0] s = vpn[1:0];
    int way = -1;
    if (fl) begin
      for (int i = 0; i < 4; i++) for (int w = 0; w < 4; w++) m_v[i][w] = 0;
      return;
    end
    if (!fv) return;
    for (int w = 0; w < 4; w++)
      if (way < 0 && m_v[s][w] && m_tag[s][w] == vpn[7:2]) way = w;
    for (int w = 0; w < 4; w++)
      if (way < 0 && !m_v[s][w]) way = w;
    if (way < 0) begin way = int'(m_rr[s]); m_rr[s] = m_rr[s] + 2'd1; end
    m_v[s][way] = 1; m_tag[s][way] = vpn[7:2]; m_ppn[s][way] = ppn;
    m_rd[s][way] = rd; m_wr[s][way] = wr; m_us[s][way] = us;
  endfunction

  task automatic step(bit rq, bit [13:0] va, bit wr, bit sup, bit fl, bit fv,
                      bit [7:0] vpn, bit [5:0] ppn, bit frd, bit fwr, bit fus, string req);
    bit [15:0] exp_v, got;
    req_valid = rq; req_vaddr = va; req_write = wr; req_super = sup; flush = fl;
    fill_valid = fv; fill_vpn = vpn; fill_ppn = ppn; fill_rd = frd; fill_wr = fwr; fill_user = fus;
    exp_v = expect_rsp(rq, va, wr, sup);
    model_update(fl, fv, vpn, ppn, frd, fwr, fus);
    @(posedge clk); #1;
    got = {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr};
    nvec++;
    if (got !== exp_v) begin
      nbad++;
      $display("FAIL %s va=%h got=%h exp=%h", req, va, got, exp_v);
    end
  endtask

  task automatic look(bit [13:0] va, bit wr, bit sup, string req);
    step(1, va, wr, sup, 0, 0, 8'h0, 6'h0, 0, 0, 0, req);
  endtask

  task automatic fill(bit [7:0] vpn, bit [5:0] ppn, bit rd, bit wr, bit us, string req);
    step(0, 14'h0, 0, 0, 0, 1, vpn, ppn, rd, wr, us, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd20240607);
    for (int i = 0; i < 4; i++) begin
      m_rr[i] = 0;
      for (int w = 0; w < 4; w++) begin
        m_v[i][w] = 0; m_tag[i][w] = 0; m_ppn[i][w] = 0; m_rd[i][w] = 0; m_wr[i][w] = 0; m_us[i][w] = 0;
      end
    end
    #(CLK_PERIOD * 2 + 1);
    nvec++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr} !== 16'h0) begin
      nbad++; $display("FAIL R10 reset outputs got=%b exp=0", {rsp_valid, rsp_hit, rsp_miss, rsp_fault});
    end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    look(14'h03D4, 0, 1, "R10 empty after reset");
    look(14'h03D4, 0, 1, "R3 miss");
    fill(8'h0F, 6'h0D, 1, 1, 1, "R6 fill");
    look(14'h03D4, 0, 0, "R1 hit paddr 0x354");
    look(14'h03FF, 1, 0, "R1 offset passthrough");
    look(14'h07D4, 0, 1, "R2 same set other tag");
    look(14'h0394, 0, 1, "R2 other set same tag");
    step(0, 14'h0, 0, 0, 0, 0, 8'h0, 6'h0, 0, 0, 0, "R9 idle");
    fill(8'h21, 6'h2A, 1, 0, 0, "R6 fill ro super");
    look(14'h0840, 1, 1, "R4 write to read-only");
    look(14'h0840, 0, 1, "R5 super read ok");
    look(14'h0840, 0, 0, "R5 user to super page");
    fill(8'h22, 6'h15, 0, 1, 1, "R6 fill wo");
    look(14'h0880, 0, 1, "R4 read without rd");
    look(14'h0880, 1, 0, "R4 write ok");
    // five tags into set 1: fifth evicts via round-robin
    for (int t = 0; t < 5; t++) fill({t[5:0], 2'b01}, 6'(t + 8), 1, 1, 1, "R6 set fill");
    for (int t = 0; t < 5; t++) look({t[5:0], 2'b01, 6'h11}, 0, 0, "R6 eviction");
    fill(8'h05, 6'h3F, 1, 1, 1, "R6 refill present tag");
    for (int t = 0; t < 5; t++) look({t[5:0], 2'b01, 6'h22}, 0, 0, "R6 overwrite");
    step(1, 14'h1AC0, 0, 1, 0, 1, 8'h6B, 6'h07, 1, 1, 1, "R8 lookup during fill");
    look(14'h1AC0, 0, 1, "R8 after fill");
    step(1, 14'h1AC0, 0, 1, 1, 1, 8'h7F, 6'h01, 1, 1, 1, "R8 lookup during flush");
    look(14'h1AC0, 0, 1, "R7 flushed");
    look(14'h1FC0, 0, 1, "R7 flush drops fill");
    look(14'h03D4, 0, 1, "R7 flushed old");

    for (int i = 0; i < 4000; i++) begin
      bit [13:0] va;
      bit [7:0]  vpn;
      bit fl, fv;
      va  = {3'b000, 3'($urandom % 6), 2'($urandom), 6'($urandom)};
      vpn = {3'b000, 3'($urandom % 6), 2'($urandom)};
      fl  = ($urandom % 100) < 2;
      fv  = ($urandom % 100) < 35;
      step(($urandom % 100) < 80, va, 1'($urandom), 1'($urandom), fl, fv, vpn,
           6'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R1 R2 R4 R5 R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule